// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This always-on unit sits between the shared peripheral interrupt lines and the interrupt distributor of a dual-core processor. Every line passes straight through to the distributor unchanged. Alongside that path, the unit keeps one bank of enable registers per CPU. A small register bus lets software set or clear those enables one 32-bit word at a time.

For each CPU, the unit raises a wakeup request while any interrupt that is enabled for that CPU is pending. It also answers a standby controller's idle request for that CPU. The acknowledge is granted only while the CPU has no enabled interrupt pending, so the CPU cannot enter standby with a wakeup source already active. The enable masks control wakeup and idle permission only. They never block delivery to the distributor.

Top module: `wkg_top`

## Requirements
- R1: `irq_out` equals `irq_in` in the same cycle, whatever the enable state.
- R2: After reset, every enable register of both CPUs reads 0, and `wake_o` and `idle_ack` are low.
- R3: The enable register for CPU c and index i sits at byte address c*0x400 + 4*i, with i from 0 to 3. Address bits [1:0] are ignored. Interrupt line n is controlled by bit n%32 of register n>>5. Read data appears on `bus_rdata` one clock after the read request, and it holds there until the next read.
- R4: `wake_o[c]` is high when at least one line is pending whose enable bit for CPU c is 1. A change on `irq_in` reaches `wake_o` on the third rising edge, after two synchronizer flops and one output register.
- R5: The two CPUs' enables are independent. A line enabled only for one CPU never raises the other CPU's wakeup, and never withholds the other CPU's idle acknowledge.
- R6: Writing 0xFFFFFFFF to a register enables all 32 of its lines. Writing 0 masks all 32 of them.
- R7: An access to any address other than the eight enable registers returns 0 on a read and changes no register on a write.
- R8: With `wake_o[c]` low, `idle_ack[c]` rises on the first rising edge after `idle_req[c]` is sampled high.
- R9: While `wake_o[c]` is high, `idle_ack[c]` stays low. It rises on the edge after `wake_o[c]` falls if the request is still held.
- R10: `idle_ack[c]` falls on the first rising edge after `idle_req[c]` is sampled low.
- R11: A register write takes effect on `wake_o` on the rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 128 | Shared peripheral interrupt lines, level-sensitive |
| irq_out | output | 128 | Lines forwarded to the distributor |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wake_o | output | 2 | Per-CPU wakeup request |
| idle_req | input | 2 | Per-CPU idle request from the standby controller |
| idle_ack | output | 2 | Per-CPU idle acknowledge |

## Verification
Each result has its own delay, and the bench samples at exactly that point:
- `irq_out` is combinational and is checked 1 ns after the drive.
- An interrupt change is checked 2 ns after the third rising edge that follows the drive.
- A write's effect on the wakeup is checked after the next edge. It is also checked once just before that edge, to show the old value still holds.
- Read data is sampled at the falling edge after the latching edge.
- The idle acknowledge is checked one edge after a change on the request. When it waits on a wakeup that is falling, it is checked four edges after the interrupt drops, and once more one edge earlier to show it is still low.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
   localparam int unsigned LANE_W = 32;
   localparam int unsigned BYTE_LSB = 2;

   function automatic int unsigned regs_for(input int unsigned lines);
      return (lines + LANE_W - 1) / LANE_W;
   endfunction
endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
   parameter int unsigned WIDTH  = 128,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkg_sync: at least two stages required");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wkg_mask_bank.sv
module wkg_mask_bank
   import wkg_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned WA_W      = 10,
   parameter int unsigned BASE_WORD = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WA_W-1:0]            word_addr,
   input  logic                       wr_en,
   input  logic [LANE_W-1:0]          wdata,
   output logic                       hit_o,
   output logic [LANE_W-1:0]          rd_word_o,
   output logic [NUM_REGS*LANE_W-1:0] mask_o
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);
   localparam logic [WA_W-1:0] BASE_V = WA_W'(BASE_WORD);
   localparam logic [WA_W-1:0] NREG_V = WA_W'(NUM_REGS);

   generate
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("wkg_mask_bank: NUM_REGS must be at least 2");
      end
   endgenerate

   logic [LANE_W-1:0] regs [NUM_REGS];
   logic [WA_W-1:0]   off;
   logic [IDX_W-1:0]  idx;

   assign off   = word_addr - BASE_V;
   assign hit_o = (word_addr >= BASE_V) && (off < NREG_V);
   assign idx   = off[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
      end else if (wr_en && hit_o) begin
         regs[idx] <= wdata;
      end
   end

   assign rd_word_o = hit_o ? regs[idx] : '0;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
      assign mask_o[r*LANE_W +: LANE_W] = regs[r];
   end

   // R7
   miss_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit_o) |=> $stable(mask_o));
endmodule

// File: rtl/wkg_cpu_wake.sv
module wkg_cpu_wake #(
   parameter int unsigned NUM_LINES = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_sync_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic                 idle_req_i,
   output logic                 wake_o,
   output logic                 idle_ack_o
);
   logic wake_q;
   logic ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         wake_q <= |(irq_sync_i & mask_i);
         ack_q  <= idle_req_i & ~wake_q;
      end
   end

   assign wake_o     = wake_q;
   assign idle_ack_o = ack_q;

   // R4
   wake_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q == $past(|(irq_sync_i & mask_i)));
   // R9
   ack_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> ($past(idle_req_i) && !$past(wake_q)));
   // R10
   ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_req_i |=> !ack_q);
   // R8
   ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_req_i && !wake_q) |=> ack_q);
endmodule

// File: rtl/wkg_top.sv
module wkg_top
   import wkg_pkg::*;
#(
   parameter int unsigned NUM_CPU    = 2,
   parameter int unsigned NUM_LINES  = 128,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned CPU_STRIDE = 32'h400,
   parameter int unsigned SYNC_STG   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] irq_out,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CPU-1:0]   wake_o,
   input  logic [NUM_CPU-1:0]   idle_req,
   output logic [NUM_CPU-1:0]   idle_ack
);
   localparam int unsigned NUM_REGS = regs_for(NUM_LINES);
   localparam int unsigned WA_W     = ADDR_W - BYTE_LSB;

   generate
      if (NUM_LINES % LANE_W != 0) begin : g_bad_lines
         $error("wkg_top: NUM_LINES must be a multiple of 32");
      end
      if (CPU_STRIDE < NUM_REGS * 4) begin : g_bad_stride
         $error("wkg_top: CPU_STRIDE overlaps banks");
      end
      if ((NUM_CPU * CPU_STRIDE) > (1 << ADDR_W)) begin : g_bad_addr
         $error("wkg_top: ADDR_W too narrow for all banks");
      end
   endgenerate

   // R1: pass-through
   assign irq_out = irq_in;

   logic [WA_W-1:0] word_addr;
   logic            unused_lsb;
   assign word_addr  = bus_addr[ADDR_W-1:BYTE_LSB];
   assign unused_lsb = ^bus_addr[BYTE_LSB-1:0];

   logic [NUM_LINES-1:0] irq_sync;
   wkg_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(irq_in), .q_o(irq_sync)
   );

   logic [NUM_CPU-1:0] bank_hit;
   logic [LANE_W-1:0]  bank_rd [NUM_CPU];

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_LINES-1:0] mask;

      wkg_mask_bank #(
         .NUM_REGS (NUM_REGS),
         .WA_W     (WA_W),
         .BASE_WORD(c * CPU_STRIDE / 4)
      ) bank_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .word_addr(word_addr),
         .wr_en    (bus_en && bus_we),
         .wdata    (bus_wdata),
         .hit_o    (bank_hit[c]),
         .rd_word_o(bank_rd[c]),
         .mask_o   (mask)
      );

      wkg_cpu_wake #(.NUM_LINES(NUM_LINES)) wake_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .irq_sync_i(irq_sync),
         .mask_i    (mask),
         .idle_req_i(idle_req[c]),
         .wake_o    (wake_o[c]),
         .idle_ack_o(idle_ack[c])
      );
   end

   logic [LANE_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CPU; c++) rd_mux |= bank_rd[c];
   end

   logic [LANE_W-1:0] rdata_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (bus_en && !bus_we) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;

   // R3
   one_bank_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit));
   // R7
   miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && !(|bank_hit)) |=> (bus_rdata == '0));
   // R3
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/wkg_top_tb_top.sv
module wkg_top_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] irq_in = '0;
   logic [127:0] irq_out;
   logic         bus_en = 1'b0;
   logic         bus_we = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [1:0]   wake_o;
   logic [1:0]   idle_req = '0;
   logic [1:0]   idle_ack;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   wkg_top dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wake_o(wake_o), .idle_req(idle_req), .idle_ack(idle_ack)
   );

   typedef struct packed {
      logic [6:0] irq_line;
      logic [6:0] en_line;
      logic [1:0] en_cpus;
      logic [1:0] exp_wake;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{7'd5,   7'd5,   2'b01, 2'b01},
      '{7'd40,  7'd40,  2'b10, 2'b10},
      '{7'd127, 7'd127, 2'b11, 2'b11},
      '{7'd64,  7'd65,  2'b11, 2'b00},
      '{7'd31,  7'd31,  2'b10, 2'b10},
      '{7'd96,  7'd0,   2'b01, 2'b00}
   };

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_en = 1'b0;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   function automatic logic [11:0] reg_addr(input int cpu, input int idx);
      return 12'(cpu * 12'h400 + idx * 4);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R2: reset state
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < 4; i++) begin
            bus_rd(reg_addr(c, i), rd);
            check("R2 reset mask", 128'(rd), 128'h0);
         end
      check("R2 reset wake", 128'(wake_o), 128'h0);
      check("R2 reset ack", 128'(idle_ack), 128'h0);

      // R1: pass-through with masks clear
      @(negedge clk);
      irq_in = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hF0F0_0F0F};
      #1 check("R1 passthrough", irq_out, irq_in);
      irq_in = '0;
      #1 check("R1 passthrough zero", irq_out, 128'h0);
      settle(3);

      // R4 R5 R3: vector table
      for (int v = 0; v < 6; v++) begin
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < 4; i++) bus_wr(reg_addr(c, i), 32'h0);
         for (int c = 0; c < 2; c++)
            if (VECS[v].en_cpus[c])
               bus_wr(reg_addr(c, int'(VECS[v].en_line >> 5)),
                      32'h1 << VECS[v].en_line[4:0]);
         for (int c = 0; c < 2; c++) begin
            bus_rd(reg_addr(c, int'(VECS[v].en_line >> 5)) | 12'h3, rd);
            check("R3 readback", 128'(rd),
                  VECS[v].en_cpus[c] ? 128'(32'h1 << VECS[v].en_line[4:0]) : 128'h0);
         end
         @(negedge clk);
         irq_in = '0; irq_in[VECS[v].irq_line] = 1'b1;
         settle(2);
         check("R4 not before third edge", 128'(wake_o), 128'h0);
         settle(1);
         check("R4 R5 wake", 128'(wake_o), 128'(VECS[v].exp_wake));
         @(negedge clk); irq_in = '0;
         settle(3);
         check("R4 wake clears", 128'(wake_o), 128'h0);
      end

      // R6 R11: whole-register enable and mask
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < 4; i++) bus_wr(reg_addr(c, i), 32'h0);
      @(negedge clk); irq_in = '0; irq_in[70] = 1'b1;
      settle(3);
      check("R6 masked", 128'(wake_o), 128'h0);
      bus_wr(reg_addr(1, 2), 32'hFFFF_FFFF);
      #1 check("R11 old value at write edge", 128'(wake_o), 128'h0);
      settle(1);
      check("R6 R11 all ones", 128'(wake_o), 128'b10);
      bus_wr(reg_addr(1, 2), 32'h0);
      settle(1);
      check("R6 R11 all zeros", 128'(wake_o), 128'h0);
      @(negedge clk); irq_in = '0;
      settle(3);

      // R7: invalid addresses
      bus_wr(reg_addr(0, 1), 32'hA5A5_0001);
      bus_wr(12'h010, 32'hFFFF_FFFF);
      bus_wr(12'h800, 32'hFFFF_FFFF);
      bus_wr(12'h200, 32'hFFFF_FFFF);
      bus_rd(12'h010, rd); check("R7 read 0x010", 128'(rd), 128'h0);
      bus_rd(12'h800, rd); check("R7 read 0x800", 128'(rd), 128'h0);
      bus_rd(12'h200, rd); check("R7 read 0x200", 128'(rd), 128'h0);
      bus_rd(reg_addr(0, 1), rd); check("R7 valid reg intact", 128'(rd), 128'hA5A5_0001);
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < 4; i++) begin
            bus_rd(reg_addr(c, i), rd);
            check("R7 no stray write", 128'(rd), (c == 0 && i == 1) ? 128'hA5A5_0001 : 128'h0);
         end
      bus_wr(reg_addr(0, 1), 32'h0);

      // R8 R10: quiet CPU handshake
      @(negedge clk); idle_req[1] = 1'b1;
      #1 check("R8 not early", 128'(idle_ack), 128'h0);
      settle(1);
      check("R8 ack one edge", 128'(idle_ack), 128'b10);
      @(negedge clk); idle_req[1] = 1'b0;
      settle(1);
      check("R10 ack drops", 128'(idle_ack), 128'h0);

      // R9 R5: withheld ack while wake pending
      bus_wr(reg_addr(0, 0), 32'h1 << 9);
      @(negedge clk); irq_in = '0; irq_in[9] = 1'b1;
      settle(3);
      check("R9 wake set", 128'(wake_o), 128'b01);
      @(negedge clk); idle_req = 2'b11;
      settle(2);
      check("R9 R5 ack withheld cpu0 only", 128'(idle_ack), 128'b10);
      @(negedge clk); irq_in = '0;
      settle(3);
      check("R9 wake fell, ack still low", 128'({wake_o, idle_ack}), 128'b0010);
      settle(1);
      check("R9 ack after quiet", 128'(idle_ack), 128'b11);
      @(negedge clk); idle_req = 2'b00;
      settle(1);
      check("R10 both drop", 128'(idle_ack), 128'h0);

      finish_run();
   end
endmodule